// File: doc/BRIEF.md
# Grouped Clock Output Divider Bank

This block takes one fast input clock (nominally 2.5 GHz) and produces two banks of divided clocks. Bank A has four outputs and bank B has five. Each bank has its own 2-bit ratio code, so the two banks can run at different output frequencies. Bank A can give 62.5, 125, 156.25 or 312.5 MHz. Bank B can give 62.5, 125, 250 or 312.5 MHz. Each bank also has a 2-bit gating code that turns on the whole bank, a low-numbered subset of its outputs, or (bank A only) none of them. A per-output valid bit shows which outputs are currently driven. The pads that would turn a gated output high-impedance are outside this block.

Both banks restart from one synchronous reset. The ratio codes are captured only while reset is held, so a ratio change reaches the outputs only through a reset. After reset is released, every output rises on the same input edge, which keeps the banks phase-aligned. One pairing of gating codes is a test combination that is not valid for operation, and the block raises an error flag when it is selected.

Top module: `clkdiv_bank`

## Requirements
- R1: The reset `rstN` is active low and synchronous. After any input edge at which `rstN` is 0, every bit of `clkOutA`, `clkOutB`, `validA` and `validB` is 0, and `cfgError` is 0.
- R2: Bank A ratio code `divSelA` maps 0 to divide by 40, 1 to divide by 20, 2 to divide by 16 and 3 to divide by 8.
- R3: Bank B ratio code `divSelB` maps 0 to divide by 40, 1 to divide by 20, 2 to divide by 10 and 3 to divide by 8. This setting is independent of bank A.
- R4: Every enabled output is high for exactly half its ratio, counted in input cycles, and then low for the same number of cycles.
- R5: Every enabled output of both banks is high after the first input edge with `rstN` at 1. This is the common first rising edge.
- R6: Bank A gating code `enModeA`: 0 enables all four outputs, 1 enables outputs 0 and 1 only, 2 enables none, and 3 enables all four. A disabled output is held at 0 and its `validA` bit is 0. An enabled output has its `validA` bit at 1.
- R7: Bank B gating code `enModeB`: 0 enables all five outputs, 1 enables output 0 only, 2 enables outputs 0 to 2 only, and 3 enables all five. Disabled outputs and their `validB` bits behave as in R6.
- R8: `cfgError` is 1 after any running edge at which `enModeA` is 2 and `enModeB` is 1 at the same time. It is 0 after any other running edge.
- R9: A change of `divSelA` or `divSelB` while running has no effect on the output period. The new ratio is used only after the next reset.
- R10: A change of a gating code while running takes effect after the next input edge. It does not restart or shift the phase of the divided clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Synchronous active-low reset; holds every output low |
| divSelA | input | 2 | Bank A ratio code, captured during reset |
| divSelB | input | 2 | Bank B ratio code, captured during reset |
| enModeA | input | 2 | Bank A gating code |
| enModeB | input | 2 | Bank B gating code |
| clkOutA | output | 4 | Bank A divided clocks |
| clkOutB | output | 5 | Bank B divided clocks |
| validA | output | 4 | Bank A per-output enable status |
| validB | output | 5 | Bank B per-output enable status |
| cfgError | output | 1 | Invalid gating-code combination flag |

## Verification
The hardest case to reach is the one where the ratio code at the pins and the ratio in use differ. This only happens after `divSelA` or `divSelB` moves while the banks are running. The stimulus starts a run with divide by 40, switches the code to divide by 8 partway through the first high phase, and checks every later cycle against the old period. A later reset then shows that the new ratio is used. A second directed run changes the gating codes mid-run and checks that the waveform of the outputs that stay enabled continues without a break.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Strobes from the control unit to each bank datapath
  typedef struct packed {
    logic capture;   // reset active: load ratio code, clear counter and phase
    logic firstRun;  // the coming edge is the first one after reset release
  } divStrobe_t;

  localparam logic [1:0] GATE_A_OFF    = 2'b10;
  localparam logic [1:0] GATE_A_PAIR   = 2'b01;
  localparam logic [1:0] GATE_B_SINGLE = 2'b01;
  localparam logic [1:0] GATE_B_TRIPLE = 2'b10;

  // Half of the division ratio for a bank and code
  function automatic int unsigned halfRatio(input bit isB, input logic [1:0] code);
    case (code)
      2'd0:    return 20;
      2'd1:    return 10;
      2'd2:    return isB ? 5 : 8;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_A = 4,
  parameter int NUM_B = 5,
  parameter int SUB_A = 2,
  parameter int SUB_B = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       enModeA,
  input  logic [1:0]       enModeB,
  output divStrobe_t       strb,
  output logic [NUM_A-1:0] maskA,
  output logic [NUM_B-1:0] maskB,
  output logic             cfgError
);

  localparam logic [NUM_A-1:0] ALL_A  = '1;
  localparam logic [NUM_B-1:0] ALL_B  = '1;
  localparam logic [NUM_A-1:0] PART_A = NUM_A'((1 << SUB_A) - 1);
  localparam logic [NUM_B-1:0] PART_B = NUM_B'((1 << SUB_B) - 1);
  localparam logic [NUM_B-1:0] ONE_B  = NUM_B'(1);

  logic             startedQ;
  logic [NUM_A-1:0] nextMaskA;
  logic [NUM_B-1:0] nextMaskB;

  always_comb begin
    case (enModeA)
      GATE_A_PAIR: nextMaskA = PART_A;
      GATE_A_OFF:  nextMaskA = '0;
      default:     nextMaskA = ALL_A;
    endcase
    case (enModeB)
      GATE_B_SINGLE: nextMaskB = ONE_B;
      GATE_B_TRIPLE: nextMaskB = PART_B;
      default:       nextMaskB = ALL_B;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startedQ <= 1'b0;
      maskA    <= '0;
      maskB    <= '0;
      cfgError <= 1'b0;
    end else begin
      startedQ <= 1'b1;
      maskA    <= nextMaskA;
      maskB    <= nextMaskB;
      cfgError <= (enModeA == GATE_A_OFF) && (enModeB == GATE_B_SINGLE);
    end
  end

  assign strb.capture  = ~rstN;
  assign strb.firstRun = rstN & ~startedQ;

  // R7
  bank_b_first_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    startedQ |-> maskB[0]);

  // R6
  bank_a_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskA[NUM_A-1:SUB_A] != '0) |-> (maskA[SUB_A-1:0] == PART_A[SUB_A-1:0]));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (maskA == '0 && maskB == '0 && !cfgError));

endmodule

// File: rtl/clkdiv_group.sv
module clkdiv_group
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter bit IS_B    = 1'b0,
  parameter int MAX_HALF = 20,
  localparam int CNT_W  = $clog2(MAX_HALF)
) (
  input  logic               clk,
  input  divStrobe_t         strb,
  input  logic [1:0]         divSel,
  input  logic [NUM_OUT-1:0] mask,
  output logic [NUM_OUT-1:0] clkOut
);

  logic [1:0]       divCodeQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadVal;
  logic             phaseQ;

  assign reloadVal = CNT_W'(halfRatio(IS_B, divCodeQ) - 1);

  // Counter loads zero at reset so the first running edge toggles the phase
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      divCodeQ <= divSel;
      cntQ     <= '0;
      phaseQ   <= 1'b0;
    end else if (cntQ == '0) begin
      cntQ   <= reloadVal;
      phaseQ <= ~phaseQ;
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gate
    assign clkOut[g] = phaseQ & mask[g];
  end

  // R5
  first_edge_high_chk: assert property (@(posedge clk) disable iff (strb.capture)
    strb.firstRun |=> phaseQ);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (strb.capture)
    (cntQ != '0) |=> $stable(phaseQ));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (strb.capture)
    cntQ <= reloadVal);

  // R9
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (strb.capture)
    !strb.firstRun |=> $stable(divCodeQ));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_A = 4,
  parameter int NUM_B = 5,
  parameter int SUB_A = 2,
  parameter int SUB_B = 3,
  parameter int MAX_HALF = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       divSelA,
  input  logic [1:0]       divSelB,
  input  logic [1:0]       enModeA,
  input  logic [1:0]       enModeB,
  output logic [NUM_A-1:0] clkOutA,
  output logic [NUM_B-1:0] clkOutB,
  output logic [NUM_A-1:0] validA,
  output logic [NUM_B-1:0] validB,
  output logic             cfgError
);

  divStrobe_t       strb;
  logic [NUM_A-1:0] maskA;
  logic [NUM_B-1:0] maskB;

  clkdiv_ctrl #(.NUM_A(NUM_A), .NUM_B(NUM_B), .SUB_A(SUB_A), .SUB_B(SUB_B)) uCtrl (
    .clk(clk), .rstN(rstN), .enModeA(enModeA), .enModeB(enModeB),
    .strb(strb), .maskA(maskA), .maskB(maskB), .cfgError(cfgError)
  );

  clkdiv_group #(.NUM_OUT(NUM_A), .IS_B(1'b0), .MAX_HALF(MAX_HALF)) uGroupA (
    .clk(clk), .strb(strb), .divSel(divSelA), .mask(maskA), .clkOut(clkOutA)
  );

  clkdiv_group #(.NUM_OUT(NUM_B), .IS_B(1'b1), .MAX_HALF(MAX_HALF)) uGroupB (
    .clk(clk), .strb(strb), .divSel(divSelB), .mask(maskB), .clkOut(clkOutB)
  );

  assign validA = maskA;
  assign validB = maskB;

  // R5
  banks_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskA[0] && maskB[0] && $past(rstN) && !$past(rstN, 2) && $past(1'b1, 2))
      |-> (clkOutA[0] && clkOutB[0]));

  // R6
  gated_low_chk: assert property (@(posedge clk)
    ((clkOutA & ~validA) == '0) && ((clkOutB & ~validB) == '0));

endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] divSelA = 2'd0, divSelB = 2'd0, enModeA = 2'd0, enModeB = 2'd0;
  logic [3:0] clkOutA, validA;
  logic [4:0] clkOutB, validB;
  logic       cfgError;

  int nChecks = 0;
  int nFails  = 0;
  int k = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkdiv_bank dut (
    .clk(clk), .rstN(rstN), .divSelA(divSelA), .divSelB(divSelB),
    .enModeA(enModeA), .enModeB(enModeB), .clkOutA(clkOutA), .clkOutB(clkOutB),
    .validA(validA), .validB(validB), .cfgError(cfgError)
  );

  typedef struct packed {
    logic [1:0] dA, dB, eA, eB;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0},
    '{2'd1, 2'd2, 2'd1, 2'd2},
    '{2'd2, 2'd3, 2'd3, 2'd1},
    '{2'd3, 2'd1, 2'd0, 2'd3},
    '{2'd2, 2'd2, 2'd2, 2'd0},
    '{2'd1, 2'd0, 2'd2, 2'd1},
    '{2'd3, 2'd3, 2'd1, 2'd1},
    '{2'd0, 2'd2, 2'd3, 2'd2}
  };

  function automatic int halfA(input logic [1:0] c);
    case (c) 2'd0: return 20; 2'd1: return 10; 2'd2: return 8; default: return 4; endcase
  endfunction
  function automatic int halfB(input logic [1:0] c);
    case (c) 2'd0: return 20; 2'd1: return 10; 2'd2: return 5; default: return 4; endcase
  endfunction
  function automatic logic [3:0] mA(input logic [1:0] e);
    case (e) 2'd1: return 4'b0011; 2'd2: return 4'b0000; default: return 4'b1111; endcase
  endfunction
  function automatic logic [4:0] mB(input logic [1:0] e);
    case (e) 2'd1: return 5'b00001; 2'd2: return 5'b00111; default: return 5'b11111; endcase
  endfunction
  function automatic bit phaseAt(input int kk, input int h);
    return (((kk - 1) / h) % 2) == 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, k);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(PERIOD/4);
    if (rstN) k++;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) step();
    chk(clkOutA == 0 && clkOutB == 0, "R1 outputs", {clkOutA, clkOutB}, 0);
    chk(validA == 0 && validB == 0 && !cfgError, "R1 valid/error",
        {validA, validB, cfgError}, 0);
    rstN = 1'b1;
    k = 0;
  endtask

  // Compare both banks at running cycle k with given ratios and gating
  task automatic cmpOut(input int hA, input int hB, input logic [1:0] eA,
                        input logic [1:0] eB, input string tag);
    logic [3:0] xA;
    logic [4:0] xB;
    xA = phaseAt(k, hA) ? mA(eA) : 4'b0;
    xB = phaseAt(k, hB) ? mB(eB) : 5'b0;
    chk(clkOutA == xA, {tag, " bank A"}, clkOutA, xA);
    chk(clkOutB == xB, {tag, " bank B"}, clkOutB, xB);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(PERIOD/4);
    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      divSelA = VECS[v].dA; divSelB = VECS[v].dB;
      enModeA = VECS[v].eA; enModeB = VECS[v].eB;
      doReset();
      for (int c = 0; c < 100; c++) begin
        step();
        cmpOut(halfA(VECS[v].dA), halfB(VECS[v].dB), VECS[v].eA, VECS[v].eB,
               "R2/R3/R4");
        if (k == 1) begin
          chk(validA == mA(VECS[v].eA), "R6 validA", validA, mA(VECS[v].eA));
          chk(validB == mB(VECS[v].eB), "R7 validB", validB, mB(VECS[v].eB));
          chk(cfgError == (VECS[v].eA == 2'd2 && VECS[v].eB == 2'd1), "R8 error",
              cfgError, (VECS[v].eA == 2'd2 && VECS[v].eB == 2'd1));
          // R5: common first rising edge
          chk(clkOutA[0] == (VECS[v].eA != 2'd2) && clkOutB[0] == 1'b1, "R5 first edge",
              {clkOutA[0], clkOutB[0]}, {(VECS[v].eA != 2'd2), 1'b1});
        end
      end
    end

    // R9: ratio change mid-run is ignored
    divSelA = 2'd0; divSelB = 2'd0; enModeA = 2'd0; enModeB = 2'd0;
    doReset();
    for (int c = 0; c < 90; c++) begin
      step();
      if (k == 7) begin divSelA = 2'd3; divSelB = 2'd3; end
      cmpOut(20, 20, 2'd0, 2'd0, "R9 held ratio");
    end
    doReset();
    for (int c = 0; c < 20; c++) begin
      step();
      cmpOut(4, 4, 2'd0, 2'd0, "R9 new ratio after reset");
    end

    // R10: gating change mid-run keeps phase
    divSelA = 2'd1; divSelB = 2'd2; enModeA = 2'd0; enModeB = 2'd0;
    doReset();
    for (int c = 0; c < 60; c++) begin
      logic [1:0] gA, gB;
      gA = (k >= 13) ? 2'd1 : 2'd0;
      gB = (k >= 13) ? 2'd2 : 2'd0;
      step();
      if (k == 13) begin enModeA = 2'd1; enModeB = 2'd2; end
      cmpOut(10, 5, gA, gB, "R10 gating change");
    end

    // R1: reset asserted mid-run forces outputs low after the next edge
    rstN = 1'b0;
    step();
    chk(clkOutA == 0 && clkOutB == 0 && validA == 0 && validB == 0 && !cfgError,
        "R1 mid-run reset", {clkOutA, clkOutB, validA, validB}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule